// File: doc/BRIEF.md
# ADC Conversion Queue Scan Sequencer

This block is the control engine that steps through a queue of conversion command words and hands one conversion request per word to an external analog-to-digital converter. Each command word holds a channel number and a pause bit. The sequencer reads the words from a small command memory through an address/data port. It raises a start strobe with the channel number, and it waits for the converter's done pulse before moving to the next word.

Software picks a queue operating mode and sets a single-scan enable bit. In software mode the enable write starts the scan at once. In the external-edge modes and the interval-timer mode the write only arms the queue, and the selected trigger then starts it. The scan ends at a reserved channel code or after the last memory address, whichever comes first. At that point the enable bit clears itself and a completion pulse is given. In trigger-driven modes a pause bit parks the sequencer until the next trigger. A trigger that arrives while words are being converted is reported as an overrun. If the mode changes during a scan, the scan stops at once: any conversion in flight is aborted, and the new mode is applied together with the current enable value.

States: IDLE (nothing to do), ARMED (enabled, waiting for a trigger), ISSUE (fetch the word at the current address, then start it or finish), WAIT (conversion in flight), PAUSE (waiting for a trigger to resume). Transitions: IDLE→ISSUE (software mode with the enable set), IDLE→ARMED (trigger mode with the enable set), ARMED→ISSUE (trigger), ARMED→IDLE (enable written to 0), ISSUE→WAIT (start issued), ISSUE→IDLE (end code), WAIT→ISSUE (done, advance), WAIT→PAUSE (done on a paused word, trigger mode), WAIT→IDLE (done at the last address), PAUSE→ISSUE (trigger). A mode change takes any state to ISSUE, ARMED or IDLE, and resets the address to 0.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, status_o is 2'b00 (idle), ssen_o is 0, and conv_start_o, conv_abort_o, complete_o, pause_o and overrun_o are all 0.
- R2: In software mode (mode_i = 1), writing 1 to the enable while the queue is idle starts the scan at address 0 without any external trigger. Each command word gives exactly one conv_start_o pulse, with conv_chan_o equal to bits [5:0] of that word.
- R3: When the queue finishes, ssen_o returns to 0, complete_o is high for exactly one clock, and status_o returns to idle.
- R4: A word whose channel bits [5:0] equal 6'h3F ends the queue, and that word is not converted (an end code at address 0 gives zero conversions). Without an end code, the queue ends after the word at address QUEUE_DEPTH-1.
- R5: Enable writes of 0 or 1 made while status_o is active (2'b01) or paused (2'b10) are ignored. ssen_o keeps its value and the queue runs on unchanged.
- R6: In rising-edge mode (mode_i = 2), falling-edge mode (mode_i = 3) and interval-timer mode (mode_i = 4), writing 1 to the enable only arms the queue (status_o stays idle). The selected edge of ext_trig_i, or the next tmr_expire_i pulse, then starts it. Edges of the other polarity, and timer pulses while the queue is not armed, start nothing.
- R7: In a trigger-driven mode, when a word with bit 6 set completes, status_o becomes 2'b10 and pause_o pulses for one clock. The next trigger resumes the scan at the following address.
- R8: In software mode a word with bit 6 set does not pause the queue: the scan continues with the next word, and pause_o stays 0.
- R9: A trigger that arrives while status_o is active gives a one-clock overrun_o pulse, and the running sequence is not disturbed.
- R10: A change of mode_i during a scan pulses conv_abort_o if a conversion is in flight. The address returns to 0, and the new mode takes effect with the current enable value: a trigger mode with the enable set gives an armed queue that restarts at the first word on its trigger.
- R11: Every new scan, including one that follows a completed scan, begins with the word at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Queue mode: 0 off, 1 software, 2 rising edge, 3 falling edge, 4 interval timer |
| ssen_wr_i | input | 1 | Write strobe for the single-scan enable |
| ssen_wdata_i | input | 1 | Value written to the enable |
| ext_trig_i | input | 1 | External trigger level (synchronized inside) |
| tmr_expire_i | input | 1 | Interval timer expiry pulse |
| ccw_addr_o | output | ADDR_W | Command memory address |
| ccw_data_i | input | CHAN_W+1 | Command word at ccw_addr_o (pause bit on top, channel below) |
| conv_start_o | output | 1 | Start a conversion |
| conv_chan_o | output | CHAN_W | Channel of the conversion being started |
| conv_abort_o | output | 1 | Abort the conversion in flight |
| conv_done_i | input | 1 | Converter finished pulse |
| ssen_o | output | 1 | Current single-scan enable value |
| status_o | output | 2 | 00 idle, 01 active, 10 paused |
| complete_o | output | 1 | One-clock queue completion pulse |
| pause_o | output | 1 | One-clock pulse on entering pause |
| overrun_o | output | 1 | One-clock trigger overrun pulse |

## Verification
The hardest case to reach is a mode change that lands while a conversion is truly in flight, because the ISSUE cycle and the WAIT cycles alternate quickly. The bench watches for the third start strobe and changes the mode one clock later, when the sequencer is certain to sit in WAIT. It then checks that the abort strobe fired and that the queue stayed armed. A fresh trigger must then convert from the first word. Overrun and pause are reached the same way, by timing trigger pulses against the known cycles per word.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        QM_OFF      = 3'd0,
        QM_SOFT     = 3'd1,
        QM_EXT_RISE = 3'd2,
        QM_EXT_FALL = 3'd3,
        QM_TIMER    = 3'd4
    } qmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ISSUE,
        ST_WAIT,
        ST_PAUSE
    } seq_state_e;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'b00,
        QS_ACTIVE = 2'b01,
        QS_PAUSED = 2'b10
    } qstat_e;

    function automatic logic mode_is_triggered(input logic [2:0] m);
        return (m == QM_EXT_RISE) || (m == QM_EXT_FALL) || (m == QM_TIMER);
    endfunction

endpackage

// File: rtl/scan_trig_qual.sv
module scan_trig_qual
    import scan_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       ext_i,
    input  logic       tmr_i,
    output logic       trig_o
);

    logic ext_s;
    logic ext_d_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign ext_s = ext_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= SYNC_STAGES'({chain_q, ext_i});
            end
            assign ext_s = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_d_q <= 1'b0;
        else        ext_d_q <= ext_s;
    end

    always_comb begin
        unique case (mode_i)
            QM_EXT_RISE: trig_o = ext_s & ~ext_d_q;
            QM_EXT_FALL: trig_o = ~ext_s & ext_d_q;
            QM_TIMER:    trig_o = tmr_i;
            default:     trig_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/scan_enable_bit.sv
module scan_enable_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic accept_i,
    input  logic hw_clr_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                q_o <= 1'b0;
        else if (hw_clr_i)         q_o <= 1'b0;
        else if (wr_i && accept_i) q_o <= wdata_i;
    end

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !accept_i && !hw_clr_i) |=> (q_o == $past(q_o))); // R5

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int QUEUE_DEPTH = 16,
    parameter int CHAN_W      = 6,
    parameter int EXT_SYNC    = 2,
    localparam int ADDR_W     = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1,
    localparam int CCW_W      = CHAN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic              ssen_wr_i,
    input  logic              ssen_wdata_i,
    input  logic              ext_trig_i,
    input  logic              tmr_expire_i,
    output logic [ADDR_W-1:0] ccw_addr_o,
    input  logic [CCW_W-1:0]  ccw_data_i,
    output logic              conv_start_o,
    output logic [CHAN_W-1:0] conv_chan_o,
    output logic              conv_abort_o,
    input  logic              conv_done_i,
    output logic              ssen_o,
    output logic [1:0]        status_o,
    output logic              complete_o,
    output logic              pause_o,
    output logic              overrun_o
);

    localparam logic [CHAN_W-1:0] EOQ_CODE  = '1;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(QUEUE_DEPTH - 1);
    localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [2:0]        mode_q;
    logic              pbit_q;
    logic              ssen_q;
    logic              trig;
    logic              mode_chg;
    logic              eoq_now;
    logic              accept_wr;
    logic              hw_clr;
    logic              cmp_d, pause_d, ovr_d;
    logic              cmp_q, pause_q, ovr_q;

    scan_trig_qual #(.SYNC_STAGES(EXT_SYNC)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .ext_i  (ext_trig_i),
        .tmr_i  (tmr_expire_i),
        .trig_o (trig)
    );

    assign accept_wr = (state_q == ST_IDLE) || (state_q == ST_ARMED);

    scan_enable_bit u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ssen_wr_i),
        .wdata_i  (ssen_wdata_i),
        .accept_i (accept_wr),
        .hw_clr_i (hw_clr),
        .q_o      (ssen_q)
    );

    assign mode_chg = (mode_i != mode_q);
    assign eoq_now  = (ccw_data_i[CHAN_W-1:0] == EOQ_CODE);

    // next state and datapath decisions
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        cmp_d   = 1'b0;
        pause_d = 1'b0;
        hw_clr  = 1'b0;
        if (mode_chg) begin
            addr_d = '0;
            if (ssen_q && (mode_i == QM_SOFT))          state_d = ST_ISSUE;
            else if (ssen_q && mode_is_triggered(mode_i)) state_d = ST_ARMED;
            else                                        state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ssen_q && (mode_q == QM_SOFT)) begin
                        addr_d  = '0;
                        state_d = ST_ISSUE;
                    end else if (ssen_q && mode_is_triggered(mode_q)) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (!ssen_q) begin
                        state_d = ST_IDLE;
                    end else if (trig) begin
                        addr_d  = '0;
                        state_d = ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (eoq_now) begin
                        state_d = ST_IDLE;
                        cmp_d   = 1'b1;
                        hw_clr  = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (conv_done_i) begin
                        if (addr_q == LAST_ADDR) begin
                            state_d = ST_IDLE;
                            cmp_d   = 1'b1;
                            hw_clr  = 1'b1;
                        end else if (pbit_q && (mode_q != QM_SOFT)) begin
                            state_d = ST_PAUSE;
                            pause_d = 1'b1;
                        end else begin
                            addr_d  = addr_q + ADDR_ONE;
                            state_d = ST_ISSUE;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (trig) begin
                        addr_d  = addr_q + ADDR_ONE;
                        state_d = ST_ISSUE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign ovr_d = trig && !mode_chg &&
                   ((state_q == ST_ISSUE) || (state_q == ST_WAIT));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            mode_q  <= QM_OFF;
            pbit_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            mode_q  <= mode_i;
            if (state_q == ST_ISSUE) pbit_q <= ccw_data_i[CHAN_W];
        end
    end

    // registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q   <= 1'b0;
            pause_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            cmp_q   <= cmp_d;
            pause_q <= pause_d;
            ovr_q   <= ovr_d;
        end
    end

    // output decode
    always_comb begin
        conv_start_o = (state_q == ST_ISSUE) && !eoq_now && !mode_chg;
        conv_abort_o = (state_q == ST_WAIT) && mode_chg;
        conv_chan_o  = ccw_data_i[CHAN_W-1:0];
        ccw_addr_o   = addr_q;
        ssen_o       = ssen_q;
        complete_o   = cmp_q;
        pause_o      = pause_q;
        overrun_o    = ovr_q;
        unique case (state_q)
            ST_ISSUE, ST_WAIT: status_o = QS_ACTIVE;
            ST_PAUSE:          status_o = QS_PAUSED;
            default:           status_o = QS_IDLE;
        endcase
    end

    AST_ARMED_TRIG_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && ssen_q && trig && !mode_chg) |=>
        (state_q == ST_ISSUE && ccw_addr_o == '0)); // R11
    AST_ENABLE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ssen_q) |-> (complete_o || $past(ssen_wr_i && !ssen_wdata_i))); // R3
    AST_COMPLETE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o |-> (status_o == QS_IDLE && !ssen_o)); // R3
    AST_PAUSE_NOT_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        pause_o |-> (state_q == ST_PAUSE && mode_q != QM_SOFT)); // R8
    AST_ABORT_LEAVES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort_o |=> (state_q != ST_WAIT && ccw_addr_o == '0)); // R10
    AST_OVERRUN_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> $past(status_o == QS_ACTIVE)); // R9
    AST_NO_START_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (conv_chan_o != EOQ_CODE)); // R4

endmodule

// File: tb/adc_scan_sequencer_bench.sv
module adc_scan_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CW         = 6;
    localparam logic [5:0] EOQ = 6'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       ssen_wr_i = 1'b0, ssen_wdata_i = 1'b0;
    logic       ext_trig_i = 1'b0, tmr_expire_i = 1'b0;
    logic [3:0] ccw_addr_o;
    logic [6:0] ccw_data_i;
    logic       conv_start_o, conv_abort_o, conv_done_i = 1'b0;
    logic [5:0] conv_chan_o;
    logic       ssen_o, complete_o, pause_o, overrun_o;
    logic [1:0] status_o;

    logic [6:0] ccw_mem [DEPTH];
    assign ccw_data_i = ccw_mem[ccw_addr_o];

    int n_vec = 0, n_fail = 0;
    int n_start, n_cmp, n_pause, n_ovr, n_abort;
    logic [5:0] start_log [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_sequencer #(.QUEUE_DEPTH(DEPTH), .CHAN_W(CW)) u_adc_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .ssen_wr_i(ssen_wr_i), .ssen_wdata_i(ssen_wdata_i),
        .ext_trig_i(ext_trig_i), .tmr_expire_i(tmr_expire_i),
        .ccw_addr_o(ccw_addr_o), .ccw_data_i(ccw_data_i),
        .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
        .conv_abort_o(conv_abort_o), .conv_done_i(conv_done_i),
        .ssen_o(ssen_o), .status_o(status_o), .complete_o(complete_o),
        .pause_o(pause_o), .overrun_o(overrun_o)
    );

    // converter model and event monitor, sampling just after the falling edge
    initial begin
        int busy = 0, cnt = 0;
        forever begin
            @(negedge clk);
            #1;
            conv_done_i = 1'b0;
            if (rst_n) begin
                if (busy != 0) begin
                    cnt--;
                    if (cnt == 0) begin conv_done_i = 1'b1; busy = 0; end
                end
                if (conv_start_o) begin
                    if (n_start < 64) start_log[n_start] = conv_chan_o;
                    n_start++;
                    busy = 1; cnt = 2;
                end
                if (conv_abort_o) begin n_abort++; busy = 0; end
                if (complete_o) n_cmp++;
                if (pause_o) n_pause++;
                if (overrun_o) n_ovr++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_start = 0; n_cmp = 0; n_pause = 0; n_ovr = 0; n_abort = 0;
    endtask

    // n plain words with channels base+i, end code after them (if room)
    task automatic load_queue(input int n, input int base);
        for (int i = 0; i < DEPTH; i++) ccw_mem[i] = {1'b0, EOQ};
        for (int i = 0; i < n; i++) ccw_mem[i] = {1'b0, 6'(base + i)};
    endtask

    task automatic check_log(input string tag, input int n, input int base);
        for (int i = 0; i < n; i++) chk(tag, int'(start_log[i]), base + i);
    endtask

    task automatic write_en(input logic v);
        @(negedge clk); ssen_wr_i = 1'b1; ssen_wdata_i = v;
        @(negedge clk); ssen_wr_i = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk); mode_i = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic ext_level(input logic v);
        @(negedge clk); ext_trig_i = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_expire_i = 1'b1;
        @(negedge clk); tmr_expire_i = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 status", status_o, 0);
        chk("R1 enable", ssen_o, 0);
        chk("R1 strobes", {conv_start_o, conv_abort_o, complete_o, pause_o, overrun_o}, 0);
    endtask

    task automatic t_soft_end_code();
        set_mode(3'd1); load_queue(3, 20); clear_logs();
        write_en(1'b1); wait_cycles(20);
        chk("R2 starts", n_start, 3); check_log("R2 channel", 3, 20);
        chk("R4 end code stops", n_start, 3);
        chk("R3 complete once", n_cmp, 1);
        chk("R3 enable cleared", ssen_o, 0);
        chk("R3 status idle", status_o, 0);
        // empty queue and restart from first word
        load_queue(0, 0); clear_logs(); write_en(1'b1); wait_cycles(6);
        chk("R4 empty queue starts", n_start, 0);
        chk("R4 empty queue completes", n_cmp, 1);
        load_queue(2, 40); clear_logs(); write_en(1'b1); wait_cycles(15);
        chk("R11 restart first word", int'(start_log[0]), 40);
    endtask

    task automatic t_soft_full_and_busy_write();
        load_queue(DEPTH, 1); clear_logs();
        write_en(1'b1); wait_cycles(6);
        write_en(1'b0);
        chk("R5 enable held", ssen_o, 1);
        chk("R5 status active", status_o, 1);
        write_en(1'b1); wait_cycles(70);
        chk("R4 last address end", n_start, DEPTH);
        check_log("R5 sequence", DEPTH, 1);
        chk("R4 complete", n_cmp, 1);
        chk("R3 enable cleared", ssen_o, 0);
    endtask

    task automatic t_soft_pause();
        load_queue(4, 8); ccw_mem[1][6] = 1'b1; clear_logs();
        write_en(1'b1); wait_cycles(25);
        chk("R8 all converted", n_start, 4);
        chk("R8 no pause flag", n_pause, 0);
        chk("R8 complete", n_cmp, 1);
    endtask

    task automatic t_rise_arm_and_pause();
        set_mode(3'd2); load_queue(4, 30); ccw_mem[1][6] = 1'b1; clear_logs();
        tmr_expire_i = 1'b0;
        write_en(1'b1); wait_cycles(8);
        chk("R6 armed no start", n_start, 0);
        chk("R6 armed status idle", status_o, 0);
        chk("R6 armed enable", ssen_o, 1);
        ext_level(1'b1); wait_cycles(10);
        chk("R7 stop at pause", n_start, 2);
        chk("R7 paused status", status_o, 2);
        chk("R7 pause pulse", n_pause, 1);
        write_en(1'b0);
        chk("R5 paused write ignored", ssen_o, 1);
        ext_level(1'b0); wait_cycles(4);
        chk("R6 wrong edge ignored", n_start, 2);
        ext_level(1'b1); wait_cycles(15);
        chk("R7 resumed", n_start, 4);
        check_log("R7 order", 4, 30);
        chk("R7 complete", n_cmp, 1);
        ext_level(1'b0);
    endtask

    task automatic t_overrun();
        load_queue(6, 12); clear_logs();
        write_en(1'b1); ext_level(1'b1);
        ext_level(1'b0); ext_level(1'b1);
        wait_cycles(30);
        chk("R9 overrun pulse", n_ovr, 1);
        chk("R9 sequence intact", n_start, 6);
        check_log("R9 order", 6, 12);
        chk("R9 complete", n_cmp, 1);
        ext_level(1'b0);
    endtask

    task automatic t_fall();
        set_mode(3'd3); load_queue(2, 50); clear_logs();
        write_en(1'b1); ext_level(1'b1); wait_cycles(4);
        chk("R6 fall mode rising ignored", n_start, 0);
        ext_level(1'b0); wait_cycles(10);
        chk("R6 fall mode start", n_start, 2);
        check_log("R6 fall order", 2, 50);
    endtask

    task automatic t_timer();
        set_mode(3'd4); load_queue(3, 5); clear_logs();
        pulse_tmr(); wait_cycles(4);
        chk("R6 timer unarmed ignored", n_start, 0);
        write_en(1'b1); wait_cycles(4);
        chk("R6 timer armed waits", n_start, 0);
        pulse_tmr(); wait_cycles(15);
        chk("R6 timer start", n_start, 3);
        chk("R6 timer complete", n_cmp, 1);
    endtask

    task automatic t_mode_change();
        int seen = 0;
        set_mode(3'd1); load_queue(DEPTH, 2); clear_logs();
        write_en(1'b1);
        while (seen < 3) begin @(negedge clk); if (conv_start_o) seen++; end
        @(negedge clk); mode_i = 3'd2;
        wait_cycles(8);
        chk("R10 abort strobe", n_abort, 1);
        chk("R10 no further starts", n_start, 3);
        chk("R10 armed status", status_o, 0);
        chk("R10 enable kept", ssen_o, 1);
        clear_logs(); ext_level(1'b1); wait_cycles(70);
        chk("R10 restart count", n_start, DEPTH);
        chk("R11 restart first word", int'(start_log[0]), 2);
        chk("R10 complete", n_cmp, 1);
        ext_level(1'b0);
    endtask

    initial begin
        clear_logs();
        load_queue(0, 0);
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_soft_end_code();
                t_soft_full_and_busy_write();
                t_soft_pause();
                t_rise_arm_and_pause();
                t_overrun();
                t_fall();
                t_timer();
                t_mode_change();
            end
            begin
                repeat (20000) @(posedge clk);
                n_vec++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule